// File: doc/BRIEF.md
# Switch Management Access Sequencer

This block sits between a client that wants to read or write a register inside an Ethernet switch and a lower-level management bus master that performs single register transfers. The switch can be wired in one of three addressing schemes, and the sequencer turns each client access into the matching series of bus transfers. In plain direct mode one transfer goes straight to the requested device address. In offset-direct mode one transfer goes to the device address plus a configured base. In indirect mode the sequencer uses a command/data register pair at the base address. It writes a command word, polls the busy bit of that word until it clears, and moves data through the data register.

The scheme is chosen by a configuration pulse that samples a dual-chip flag, a multi-chip flag and a base address. When indirect mode is chosen, the sequencer polls until the switch reports not-busy before it accepts any client request. Polling is bounded by a cycle budget. The sequencer always makes at least two poll attempts, even when the budget has already run out. The first three attempts run back-to-back, and later attempts are spaced apart. A bus error on any transfer ends the access at once.

Top module: `mgmt_seq`

## Requirements
- R1: After reset, `req_ready`, `bus_req`, `cfg_err`, `rsp_done`, `rsp_err` and `rsp_tmo` are all 0 until a configuration is applied.
- R2: On a `cfg_apply` pulse the mode is chosen with this priority. Dual flag set gives offset-direct. Otherwise a base of 0 gives direct. Otherwise a multi flag set gives indirect. Anything else is invalid: `cfg_err` goes to 1, `req_ready` stays 0, and client requests start no bus transfer.
- R3: In direct mode an access makes exactly one bus transfer with address = device and register = register. A read returns the bus data on `rsp_rdata` in the cycle `rsp_done` pulses.
- R4: In offset-direct mode the single transfer goes to address (base + device) modulo 32.
- R5: An indirect read writes a command word to register 0 at the base address. It then reads register 0 until bit 15 reads 0, reads register 1, and returns that value with `rsp_done`. The command word has bit 15 = 1 (busy), bit 12 = 1, bits 11:10 = 2'b10 for read or 2'b01 for write, bits 9:5 = device and bits 4:0 = register.
- R6: An indirect write first writes the data to register 1 at the base, then writes the command word (write opcode) to register 0, then polls register 0 until bit 15 is 0, and then pulses `rsp_done`.
- R7: A configuration that selects indirect mode starts a poll of register 0 at the base. `req_ready` stays 0 until bit 15 reads 0.
- R8: If the budget of `TMO_CYC` cycles since polling began has run out and at least two polls have been made, the next poll decision pulses `rsp_tmo` and issues no further transfer, so no data read follows. Two polls are made even when the budget expires during the first one.
- R9: After the first and the second failed poll, the next poll request starts 2 cycles after the acknowledge. After the third and every later failed poll, it starts at least `SPACE_CYC` cycles after the acknowledge.
- R10: A transfer acknowledged with `bus_err` = 1 ends the access. `rsp_err` pulses and no further transfer is requested.
- R11: Only one access is in flight at a time. `req_ready` is 0 from the cycle after acceptance until the response. `rsp_done`, `rsp_err` and `rsp_tmo` are single-cycle pulses, and at most one is high at a time.
- R12: Once `bus_req` is raised, it and its address, register, direction and write data hold until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_apply | input | 1 | Pulse that samples the configuration inputs |
| cfg_dual | input | 1 | Part responds to an offset range of addresses |
| cfg_multi | input | 1 | Part supports indirect command/data access |
| cfg_base | input | 5 | Base bus address |
| cfg_err | output | 1 | Applied configuration is invalid |
| req_valid | input | 1 | Client access request |
| req_ready | output | 1 | Sequencer can accept an access |
| req_dev | input | 5 | Target device number |
| req_reg | input | 5 | Target register number |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Access completed |
| rsp_err | output | 1 | Access aborted by a bus error |
| rsp_tmo | output | 1 | Busy bit did not clear within the budget |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| bus_req | output | 1 | Bus transfer request |
| bus_wr | output | 1 | Transfer direction, 1 = write |
| bus_addr | output | 5 | Bus device address |
| bus_reg | output | 5 | Bus register number |
| bus_wdata | output | 16 | Transfer write data |
| bus_ack | input | 1 | Transfer finished, one cycle |
| bus_err | input | 1 | Transfer failed, valid with `bus_ack` |
| bus_rdata | input | 16 | Transfer read data, valid with `bus_ack` |

## Verification
The assertions assume that the bus master raises `bus_ack` only while `bus_req` is high, for exactly one cycle, and that `cfg_apply` arrives only while the sequencer is idle or unconfigured. The stimulus honours both rules. The bus responder acknowledges a held request after a set latency and drops the acknowledge on the next cycle. Configuration changes are applied only after the previous response has been seen, and client requests are offered only while `req_ready` is high, except in the invalid-mode test, which checks that requests are refused.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [ADDR_W-1:0] REG_CMD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_DAT = ADDR_W'(1);

  localparam logic [DATA_W-1:0] CMD_GO  = 16'h8000;
  localparam logic [DATA_W-1:0] CMD_C22 = 16'h1000;
  localparam logic [DATA_W-1:0] CMD_RD  = 16'h0800;
  localparam logic [DATA_W-1:0] CMD_WR  = 16'h0400;

  typedef enum logic [2:0] {
    MD_NONE, MD_DIRECT, MD_OFFSET, MD_INDIRECT, MD_BAD
  } mode_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_IDLE, ST_DIRECT, ST_IWDATA, ST_ICMD,
    ST_PCHK, ST_POLL, ST_PWAIT, ST_IRD
  } state_e;
endpackage

// File: rtl/mgmt_seq_mode.sv
module mgmt_seq_mode
  import mgmt_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_apply,
  input  logic              cfg_en,
  input  logic              cfg_dual,
  input  logic              cfg_multi,
  input  logic [ADDR_W-1:0] cfg_base,
  output mode_e             mode,
  output logic [ADDR_W-1:0] base,
  output logic              init_go
);
  mode_e mode_d;
  logic  load;

  always_comb begin
    if (cfg_dual)             mode_d = MD_OFFSET;
    else if (cfg_base == '0)  mode_d = MD_DIRECT;
    else if (cfg_multi)       mode_d = MD_INDIRECT;
    else                      mode_d = MD_BAD;
  end

  assign load = cfg_apply & cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MD_NONE;
      base    <= '0;
      init_go <= 1'b0;
    end else begin
      init_go <= load && (mode_d == MD_INDIRECT);
      if (load) begin
        mode <= mode_d;
        base <= cfg_base;
      end
    end
  end
endmodule

// File: rtl/mgmt_seq_timer.sv
module mgmt_seq_timer #(
  parameter int TMO_CYC   = 6250000,
  parameter int SPACE_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic budget_clr,
  input  logic space_load,
  output logic expired,
  output logic space_done
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int SW = $clog2(SPACE_CYC + 1);

  logic [TW-1:0] bud_q, bud_d;
  logic [SW-1:0] sp_q, sp_d;

  assign expired    = (bud_q == TW'(TMO_CYC));
  assign space_done = (sp_q == '0);

  always_comb begin
    bud_d = bud_q;
    if (budget_clr)    bud_d = '0;
    else if (!expired) bud_d = bud_q + TW'(1);
    sp_d = sp_q;
    if (space_load)       sp_d = SW'(SPACE_CYC);
    else if (!space_done) sp_d = sp_q - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bud_q <= '0;
      sp_q  <= '0;
    end else begin
      bud_q <= bud_d;
      sp_q  <= sp_d;
    end
  end
endmodule

// File: rtl/mgmt_seq_ctrl.sv
module mgmt_seq_ctrl
  import mgmt_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] base,
  input  logic              init_go,
  output logic              cfg_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_dev,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              rsp_tmo,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] bus_reg,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              expired,
  input  logic              space_done,
  output logic              budget_clr,
  output logic              space_load
);
  state_e            state_q, state_d;
  logic [1:0]        na_q, na_d, na_inc;
  logic              init_q, init_d;
  logic [ADDR_W-1:0] dev_q, dev_d, reg_q, reg_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wd_q, wd_d, rd_q, rd_d;
  logic              done_d, err_d, tmo_d;
  logic              mode_ok, accept;
  logic [DATA_W-1:0] cmd_word;

  assign mode_ok   = (mode == MD_DIRECT) || (mode == MD_OFFSET) || (mode == MD_INDIRECT);
  assign req_ready = (state_q == ST_IDLE) && mode_ok && !init_go;
  assign accept    = req_valid && req_ready;
  assign cfg_en    = ((state_q == ST_IDLE) || (state_q == ST_OFF)) && !init_go;
  assign na_inc    = (na_q == 2'd3) ? 2'd3 : na_q + 2'd1;
  assign cmd_word  = CMD_GO | CMD_C22 | (wr_q ? CMD_WR : CMD_RD)
                   | {{(DATA_W-2*ADDR_W){1'b0}}, dev_q, reg_q};

  // bus side, decoded from held state only
  always_comb begin
    bus_req   = (state_q == ST_DIRECT) || (state_q == ST_IWDATA) || (state_q == ST_ICMD)
             || (state_q == ST_POLL)   || (state_q == ST_IRD);
    bus_wr    = (state_q == ST_DIRECT) ? wr_q : ((state_q == ST_IWDATA) || (state_q == ST_ICMD));
    bus_addr  = base;
    bus_reg   = REG_CMD;
    bus_wdata = (state_q == ST_ICMD) ? cmd_word : wd_q;
    if (state_q == ST_DIRECT) begin
      bus_addr = (mode == MD_OFFSET) ? base + dev_q : dev_q;
      bus_reg  = reg_q;
    end else if ((state_q == ST_IWDATA) || (state_q == ST_IRD)) begin
      bus_reg  = REG_DAT;
    end
  end

  always_comb begin
    state_d = state_q; na_d = na_q; init_d = init_q;
    dev_d = dev_q; reg_d = reg_q; wr_d = wr_q; wd_d = wd_q; rd_d = rd_q;
    done_d = 1'b0; err_d = 1'b0; tmo_d = 1'b0;
    budget_clr = 1'b0; space_load = 1'b0;
    unique case (state_q)
      ST_OFF, ST_IDLE: begin
        if (init_go) begin
          state_d = ST_PCHK; init_d = 1'b1; na_d = 2'd0; budget_clr = 1'b1;
        end else if (!mode_ok) begin
          state_d = ST_OFF;
        end else if (state_q == ST_OFF) begin
          state_d = ST_IDLE;
        end else if (accept) begin
          dev_d = req_dev; reg_d = req_reg; wr_d = req_wr; wd_d = req_wdata;
          init_d = 1'b0;
          if (mode != MD_INDIRECT) state_d = ST_DIRECT;
          else                     state_d = req_wr ? ST_IWDATA : ST_ICMD;
        end
      end
      ST_DIRECT, ST_IRD: if (bus_ack) begin
        state_d = ST_IDLE;
        if (bus_err) err_d = 1'b1;
        else begin
          done_d = 1'b1;
          if (!wr_q) rd_d = bus_rdata;
        end
      end
      ST_IWDATA: if (bus_ack) begin
        if (bus_err) begin err_d = 1'b1; state_d = ST_IDLE; end
        else state_d = ST_ICMD;
      end
      ST_ICMD: if (bus_ack) begin
        if (bus_err) begin err_d = 1'b1; state_d = ST_IDLE; end
        else begin state_d = ST_PCHK; na_d = 2'd0; budget_clr = 1'b1; end
      end
      ST_PCHK: begin
        if (expired && na_q[1]) begin tmo_d = 1'b1; state_d = ST_IDLE; end
        else state_d = ST_POLL;
      end
      ST_POLL: if (bus_ack) begin
        if (bus_err) begin
          err_d = 1'b1; state_d = ST_IDLE;
        end else if (!bus_rdata[BUSY_BIT]) begin
          if (init_q)    state_d = ST_IDLE;
          else if (wr_q) begin done_d = 1'b1; state_d = ST_IDLE; end
          else           state_d = ST_IRD;
        end else begin
          na_d = na_inc;
          if (na_inc == 2'd3) begin state_d = ST_PWAIT; space_load = 1'b1; end
          else state_d = ST_PCHK;
        end
      end
      ST_PWAIT: if (space_done) state_d = ST_PCHK;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF; na_q <= 2'd0; init_q <= 1'b0;
      dev_q <= '0; reg_q <= '0; wr_q <= 1'b0; wd_q <= '0; rd_q <= '0;
      rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_tmo <= 1'b0;
    end else begin
      state_q <= state_d; na_q <= na_d; init_q <= init_d;
      dev_q <= dev_d; reg_q <= reg_d; wr_q <= wr_d; wd_q <= wd_d; rd_q <= rd_d;
      rsp_done <= done_d; rsp_err <= err_d; rsp_tmo <= tmo_d;
    end
  end

  assign rsp_rdata = rd_q;
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_seq_pkg::*;
#(
  parameter int TMO_CYC   = 6250000,
  parameter int SPACE_CYC = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_apply,
  input  logic              cfg_dual,
  input  logic              cfg_multi,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_dev,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              rsp_tmo,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] bus_reg,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  mode_e             mode;
  logic [ADDR_W-1:0] base;
  logic              init_go, cfg_en;
  logic              expired, space_done, budget_clr, space_load;

  assign cfg_err = (mode == MD_BAD);

  mgmt_seq_mode u_mode (
    .clk, .rst_n, .cfg_apply, .cfg_en, .cfg_dual, .cfg_multi, .cfg_base,
    .mode, .base, .init_go
  );

  mgmt_seq_timer #(.TMO_CYC(TMO_CYC), .SPACE_CYC(SPACE_CYC)) u_timer (
    .clk, .rst_n, .budget_clr, .space_load, .expired, .space_done
  );

  mgmt_seq_ctrl u_ctrl (
    .clk, .rst_n, .mode, .base, .init_go, .cfg_en,
    .req_valid, .req_ready, .req_dev, .req_reg, .req_wr, .req_wdata,
    .rsp_done, .rsp_err, .rsp_tmo, .rsp_rdata,
    .bus_req, .bus_wr, .bus_addr, .bus_reg, .bus_wdata,
    .bus_ack, .bus_err, .bus_rdata,
    .expired, .space_done, .budget_clr, .space_load
  );
endmodule

// File: rtl/mgmt_seq_chk.sv
module mgmt_seq_chk
  import mgmt_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_err,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              rsp_tmo,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] bus_reg,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              bus_err
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wr) && $stable(bus_addr)
                               && $stable(bus_reg) && $stable(bus_wdata)));

  assert_one_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_done, rsp_err, rsp_tmo}));

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_abort_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err) |=> !bus_req);

  assert_bad_cfg_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!req_ready && !bus_req));
endmodule

bind mgmt_seq mgmt_seq_chk u_chk (.*);

// File: tb/sim_mgmt_seq.sv
`timescale 1ns/1ps
module sim_mgmt_seq;
  localparam int TMO   = 200;
  localparam int SPACE = 20;

  logic clk, rst_n;
  logic cfg_apply, cfg_dual, cfg_multi;
  logic [4:0] cfg_base;
  logic cfg_err;
  logic req_valid, req_ready, req_wr;
  logic [4:0] req_dev, req_reg;
  logic [15:0] req_wdata;
  logic rsp_done, rsp_err, rsp_tmo;
  logic [15:0] rsp_rdata;
  logic bus_req, bus_wr, bus_ack, bus_err;
  logic [4:0] bus_addr, bus_reg;
  logic [15:0] bus_wdata, bus_rdata;

  mgmt_seq #(.TMO_CYC(TMO), .SPACE_CYC(SPACE)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model: queue of expected bus transfers
  typedef struct { bit wr; logic [4:0] a; logic [4:0] r; logic [15:0] d; } op_t;
  op_t exp_q[$];

  task automatic exp_op(input bit wr, input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    op_t o;
    o.wr = wr; o.a = a; o.r = r; o.d = d;
    exp_q.push_back(o);
  endtask

  // bus responder state
  int lat = 1, wcnt = 0, ncyc = 0, t_ack = 0, t_start = 0;
  int busy_left = 0, op_cnt = 0, err_op = -1, pn = 0;
  bit ind = 0, free_poll = 0;
  logic [4:0] base_v = '0;
  logic [15:0] rd_val = '0;

  initial begin
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      ncyc++;
      if (bus_ack) begin
        bus_ack = 1'b0; bus_err = 1'b0;
      end else if (bus_req) begin
        bit is_poll;
        is_poll = ind && !bus_wr && bus_reg == 5'd0 && bus_addr == base_v;
        if (wcnt == 0) begin
          t_start = ncyc;
          if (free_poll && is_poll && (pn == 1 || pn == 2))
            chk(t_start - t_ack == 2, "R9 back-to-back retry gap", t_start - t_ack, 2);
          if (free_poll && is_poll && pn >= 3)
            chk(t_start - t_ack >= SPACE, "R9 spaced retry gap", t_start - t_ack, SPACE);
        end
        wcnt++;
        if (wcnt >= lat) begin
          wcnt = 0;
          if (free_poll && is_poll) pn++;
          else if (exp_q.size() == 0)
            chk(0, "R10 unexpected bus transfer", {bus_wr, bus_addr, bus_reg}, 0);
          else begin
            op_t o;
            o = exp_q.pop_front();
            chk(bus_wr == o.wr && bus_addr == o.a && bus_reg == o.r && (!o.wr || bus_wdata == o.d),
                "R3/R4/R5/R6 transfer", {bus_wr, bus_addr, bus_reg, bus_wdata},
                {o.wr, o.a, o.r, o.d});
          end
          if (is_poll) begin
            if (busy_left > 0) begin bus_rdata = 16'h8123; busy_left--; end
            else bus_rdata = 16'h7FFF;
          end else bus_rdata = rd_val;
          bus_err = (op_cnt == err_op);
          op_cnt++;
          bus_ack = 1'b1;
          t_ack = ncyc;
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic configure(input bit d, input bit m, input logic [4:0] b);
    @(negedge clk);
    cfg_dual = d; cfg_multi = m; cfg_base = b; cfg_apply = 1'b1;
    @(negedge clk);
    cfg_apply = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20000 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [4:0] dv, input logic [4:0] rg, input bit wr, input logic [15:0] wd);
    wait_ready();
    op_cnt = 0;
    req_dev = dv; req_reg = rg; req_wr = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 ready low after accept", req_ready, 0);
  endtask

  task automatic wait_rsp(output int kind, output logic [15:0] data);
    kind = 0; data = '0;
    for (int i = 0; i < 20000; i++) begin
      if (rsp_done || rsp_err || rsp_tmo) begin
        kind = rsp_done ? 1 : rsp_err ? 2 : 3;
        data = rsp_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  int k;
  logic [15:0] rd;

  initial begin
    rst_n = 1'b0; cfg_apply = 1'b0; cfg_dual = 1'b0; cfg_multi = 1'b0; cfg_base = '0;
    req_valid = 1'b0; req_wr = 1'b0; req_dev = '0; req_reg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!req_ready && !bus_req && !cfg_err && !rsp_done && !rsp_err && !rsp_tmo,
        "R1 reset outputs", {req_ready, bus_req, cfg_err, rsp_done, rsp_err, rsp_tmo}, 0);

    // R3 direct mode
    configure(0, 0, 5'd0);
    exp_op(0, 5'd7, 5'd3, 0); rd_val = 16'h1234;
    issue(5'd7, 5'd3, 0, 0);
    wait_rsp(k, rd);
    chk(k == 1 && rd == 16'h1234, "R3 direct read", {k, rd}, {1, 16'h1234});
    exp_op(1, 5'd2, 5'd9, 16'hA5A5);
    issue(5'd2, 5'd9, 1, 16'hA5A5);
    wait_rsp(k, rd);
    chk(k == 1, "R3 direct write done", k, 1);
    chk(exp_q.size() == 0, "R3 all transfers seen", exp_q.size(), 0);

    // R2 invalid configuration
    configure(0, 0, 5'd4);
    @(negedge clk);
    chk(cfg_err && !req_ready, "R2 invalid mode flagged", {cfg_err, req_ready}, 2'b10);
    req_valid = 1'b1; req_dev = 5'd1;
    k = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bus_req || req_ready || rsp_done || rsp_err || rsp_tmo) k++;
    end
    req_valid = 1'b0;
    chk(k == 0, "R2 request ignored while invalid", k, 0);

    // R4 offset-direct with wrap
    configure(1, 0, 5'd8);
    @(negedge clk);
    chk(!cfg_err, "R2 cfg_err cleared", cfg_err, 0);
    exp_op(0, 5'd6, 5'd5, 0); rd_val = 16'h0BAD;
    issue(5'd30, 5'd5, 0, 0);
    wait_rsp(k, rd);
    chk(k == 1 && rd == 16'h0BAD, "R4 offset read", {k, rd}, {1, 16'h0BAD});

    // R2 priority: dual wins over multi
    configure(1, 1, 5'd2);
    exp_op(1, 5'd7, 5'd1, 16'h0F0F);
    issue(5'd5, 5'd1, 1, 16'h0F0F);
    wait_rsp(k, rd);
    chk(k == 1 && exp_q.size() == 0, "R2 dual selects offset mode", {k, exp_q.size()}, 1);

    // R7 indirect init poll
    ind = 1; base_v = 5'd4; busy_left = 2;
    repeat (3) exp_op(0, 5'd4, 5'd0, 0);
    configure(0, 1, 5'd4);
    chk(!req_ready, "R7 ready low during init", req_ready, 0);
    wait_ready();
    chk(exp_q.size() == 0 && busy_left == 0, "R7 init polled to clear", exp_q.size(), 0);

    // R5 indirect read
    busy_left = 1; rd_val = 16'hCAFE;
    exp_op(1, 5'd4, 5'd0, 16'h9864);
    exp_op(0, 5'd4, 5'd0, 0); exp_op(0, 5'd4, 5'd0, 0);
    exp_op(0, 5'd4, 5'd1, 0);
    issue(5'd3, 5'd4, 0, 0);
    wait_rsp(k, rd);
    chk(k == 1 && rd == 16'hCAFE, "R5 indirect read", {k, rd}, {1, 16'hCAFE});
    chk(exp_q.size() == 0, "R5 sequence complete", exp_q.size(), 0);

    // R6 indirect write
    exp_op(1, 5'd4, 5'd1, 16'hBEEF);
    exp_op(1, 5'd4, 5'd0, 16'h9422);
    exp_op(0, 5'd4, 5'd0, 0);
    issue(5'd1, 5'd2, 1, 16'hBEEF);
    wait_rsp(k, rd);
    chk(k == 1 && exp_q.size() == 0, "R6 indirect write", {k, exp_q.size()}, 1);

    // R10 bus error on the command write
    exp_op(1, 5'd4, 5'd1, 16'h1111);
    exp_op(1, 5'd4, 5'd0, 16'h9422);
    err_op = 1;
    issue(5'd1, 5'd2, 1, 16'h1111);
    wait_rsp(k, rd);
    chk(k == 2, "R10 error reported", k, 2);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && !bus_req, "R10 aborted", exp_q.size(), 0);
    err_op = -1;

    // R8 budget expires during first poll: still two polls
    lat = 250; busy_left = 100;
    exp_op(1, 5'd4, 5'd0, 16'h9800);
    exp_op(0, 5'd4, 5'd0, 0); exp_op(0, 5'd4, 5'd0, 0);
    issue(5'd0, 5'd0, 0, 0);
    wait_rsp(k, rd);
    chk(k == 3, "R8 timeout reported", k, 3);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && !bus_req, "R8 exactly two polls, no data read", exp_q.size(), 0);
    lat = 1; busy_left = 0;

    // R8/R9 many polls with spacing
    free_poll = 1; pn = 0; busy_left = 1000000;
    exp_op(1, 5'd4, 5'd1, 16'h0001);
    exp_op(1, 5'd4, 5'd0, 16'h9400);
    issue(5'd0, 5'd0, 1, 16'h0001);
    wait_rsp(k, rd);
    chk(k == 3, "R8 timeout after spaced polls", k, 3);
    chk(pn >= 4, "R9 poll count", pn, 4);
    repeat (5) @(negedge clk);
    chk(!bus_req && exp_q.size() == 0, "R8 no transfer after timeout", bus_req, 0);
    free_poll = 0; busy_left = 0;
    @(negedge clk);
    chk(req_ready, "R11 ready after response", req_ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule